// File: doc/BRIEF.md
# SMRAM and TSEG Access Guard

This block protects a region of system-management memory that sits at the very top of RAM. It has two byte-wide configuration registers, reached through a small write/read port. One is a control register with open, close, lock and global-enable bits. The other is an extended register with a window-enable bit and a window-size code. Every CPU byte access passes through the guard on its way to DRAM. The guard decides in the same cycle whether the access reaches memory. When it refuses a read, the read returns all-ones. When it refuses a write, the write never reaches DRAM.

Each access carries a management-mode qualifier. Management-mode accesses always reach the protected window. Other accesses reach it only while the window is disabled, or while it is opened and not closed. The lock bit is sticky until system reset. It forces the open bit clear and freezes both registers, so that untrusted code can neither reopen, move nor disable the window. Total RAM size and the size chosen by the all-ones size code are parameters.

Top module: `tseg_guard_top`

## Requirements
- R1: After a synchronous reset, both registers read 0x00, so the window is disabled and every RAM byte is readable and writable by any access.
- R2: The control register (select 0) maps open to bit 0, close to bit 1, lock to bit 2 and global enable to bit 3, and reads 0 in bits 7..4. While lock is clear, each of these bits takes the written value, and a read returns the value last written.
- R3: A control write with bit 2 set clears open on the same clock edge. After that, writes that try to set open leave it reading 0.
- R4: Lock stays set until reset. After reset, open can be written again.
- R5: The extended register (select 1) maps window enable to bit 0 and the size code to bits 2..1, and reads 0 in bits 7..3. Size code 0 selects 1 MB, code 1 selects 2 MB and code 2 selects 8 MB.
- R6: Size code 3 selects the size given by the parameter EXT_TSEG_MB (16 MB by default).
- R7: The window covers addresses from RAM size minus the selected size up to the last byte of RAM. When global enable and window enable are both set, a non-management read inside the window returns 0xFF unless open=1 and close=0.
- R8: A refused write inside the window leaves the DRAM contents unchanged, and mem_blocked is high for that access.
- R9: The byte just below the window base is ordinary memory. Non-management reads and writes to it reach DRAM.
- R10: Management-mode accesses inside an active window always reach DRAM.
- R11: With open=1 and close=0, non-management accesses reach the active window. With open=1 and close=1, they are refused.
- R12: While lock is set, writes to either register leave both registers unchanged, so the window size, the enables and the close bit stay frozen.
- R13: A configuration write takes effect at the clock edge on which the write strobe is sampled. Access decoding is combinational on the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 extended |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Contents of the selected register |
| mem_req | input | 1 | CPU byte access valid |
| mem_we | input | 1 | Access is a write |
| mem_smm | input | 1 | Access is made in management mode |
| mem_addr | input | ADDR_W | Byte address |
| mem_wdata | input | 8 | Write data |
| mem_rdata | output | 8 | Read data returned to the CPU |
| mem_blocked | output | 1 | Access refused by the guard |
| dram_addr | output | ADDR_W | Address to DRAM |
| dram_we | output | 1 | DRAM write enable |
| dram_wdata | output | 8 | DRAM write data |
| dram_rdata | input | 8 | DRAM read data |

## Verification
The window decode is tried with every size code, including the parameter-selected one. Each code is probed at the last byte below the base and at the base itself, so an off-by-one base or a wrong size value shows up at the boundary. Each boundary is accessed both without and with management mode. A dropped write is confirmed by reading the cell back in management mode. This separates "refused" from "passed but masked". The lock scenarios write open before, together with and after lock, then try to rewrite the size and the enables. This separates clearing open from freezing the registers, and a reset between them shows that the lock is sticky. One test changes the configuration while an access is held. It shows that the decode follows the registers at once and that a write lands only at the edge.

// File: rtl/tseg_guard_pkg.sv
package tseg_guard_pkg;

    localparam int unsigned MB_SHIFT = 20;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_EXT  = 1'b1;

    typedef enum logic [1:0] {
        SZ_1MB = 2'd0,
        SZ_2MB = 2'd1,
        SZ_8MB = 2'd2,
        SZ_EXT = 2'd3
    } size_code_e;

    typedef struct packed {
        logic gen_en;
        logic lock;
        logic close;
        logic open;
    } ctrl_reg_t;

    typedef struct packed {
        size_code_e size_code;
        logic       win_en;
    } ext_reg_t;

    function automatic logic [15:0] window_mb(input size_code_e code,
                                              input logic [15:0] ext_mb);
        logic [15:0] mb;
        case (code)
            SZ_1MB:  mb = 16'd1;
            SZ_2MB:  mb = 16'd2;
            SZ_8MB:  mb = 16'd8;
            default: mb = ext_mb;
        endcase
        return mb;
    endfunction

    function automatic ctrl_reg_t ctrl_from_byte(input logic [7:0] b);
        ctrl_reg_t c;
        c.open   = b[0];
        c.close  = b[1];
        c.lock   = b[2];
        c.gen_en = b[3];
        return c;
    endfunction

    function automatic ext_reg_t ext_from_byte(input logic [7:0] b);
        ext_reg_t e;
        e.win_en    = b[0];
        e.size_code = size_code_e'(b[2:1]);
        return e;
    endfunction

endpackage

// File: rtl/tseg_cfg_regs.sv
module tseg_cfg_regs
    import tseg_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic       cfg_sel,
    input  logic [7:0] cfg_wdata,
    output ctrl_reg_t  ctrl_q,
    output ext_reg_t   ext_q,
    output logic [7:0] cfg_rdata
);
    ctrl_reg_t wr_ctrl;
    ext_reg_t  wr_ext;
    logic      unused_cfg_hi;

    assign wr_ctrl       = ctrl_from_byte(cfg_wdata);
    assign wr_ext        = ext_from_byte(cfg_wdata);
    assign unused_cfg_hi = ^cfg_wdata[7:4];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ext_q  <= '0;
        end else if (cfg_wr && !ctrl_q.lock) begin
            if (cfg_sel == SEL_CTRL) begin
                ctrl_q.open   <= wr_ctrl.open && !wr_ctrl.lock;
                ctrl_q.close  <= wr_ctrl.close;
                ctrl_q.lock   <= wr_ctrl.lock;
                ctrl_q.gen_en <= wr_ctrl.gen_en;
            end else begin
                ext_q <= wr_ext;
            end
        end
    end

    always_comb begin
        if (cfg_sel == SEL_CTRL) cfg_rdata = {4'b0, ctrl_q};
        else                     cfg_rdata = {5'b0, ext_q};
    end
endmodule

// File: rtl/tseg_window_decode.sv
module tseg_window_decode
    import tseg_guard_pkg::*;
#(
    parameter int unsigned RAM_MB      = 128,
    parameter int unsigned EXT_TSEG_MB = 16,
    parameter int unsigned IDX_W       = 7
) (
    input  ext_reg_t         ext_q,
    input  logic [IDX_W-1:0] addr_mb,
    output logic             in_window
);
    logic [15:0]    size_mb;
    logic [IDX_W:0] base_mb;

    always_comb begin
        size_mb = window_mb(ext_q.size_code, EXT_TSEG_MB[15:0]);
        if (32'(size_mb) >= RAM_MB) base_mb = '0;
        else                        base_mb = (IDX_W+1)'(RAM_MB - 32'(size_mb));
        in_window = ({1'b0, addr_mb} >= base_mb);
    end
endmodule

// File: rtl/tseg_access_gate.sv
module tseg_access_gate
    import tseg_guard_pkg::*;
(
    input  ctrl_reg_t  ctrl_q,
    input  ext_reg_t   ext_q,
    input  logic       in_window,
    input  logic       mem_req,
    input  logic       mem_we,
    input  logic       mem_smm,
    input  logic [7:0] dram_rdata,
    output logic [7:0] mem_rdata,
    output logic       dram_we,
    output logic       blocked
);
    logic active;
    logic opened;
    logic allowed;

    always_comb begin
        active    = ctrl_q.gen_en && ext_q.win_en;
        opened    = ctrl_q.open && !ctrl_q.close;
        allowed   = !active || !in_window || mem_smm || opened;
        blocked   = mem_req && !allowed;
        dram_we   = mem_req && mem_we && allowed;
        mem_rdata = blocked ? 8'hFF : dram_rdata;
    end
endmodule

// File: rtl/tseg_guard_top.sv
module tseg_guard_top
    import tseg_guard_pkg::*;
#(
    parameter int unsigned RAM_MB      = 128,
    parameter int unsigned EXT_TSEG_MB = 16,
    parameter int unsigned ADDR_W      = $clog2(RAM_MB) + MB_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic              mem_smm,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    output logic [7:0]        mem_rdata,
    output logic              mem_blocked,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              dram_we,
    output logic [7:0]        dram_wdata,
    input  logic [7:0]        dram_rdata
);
    localparam int unsigned IDX_W = ADDR_W - MB_SHIFT;

    ctrl_reg_t ctrl_q;
    ext_reg_t  ext_q;
    logic      in_window;

    tseg_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ctrl_q    (ctrl_q),
        .ext_q     (ext_q),
        .cfg_rdata (cfg_rdata)
    );

    tseg_window_decode #(
        .RAM_MB      (RAM_MB),
        .EXT_TSEG_MB (EXT_TSEG_MB),
        .IDX_W       (IDX_W)
    ) u_decode (
        .ext_q     (ext_q),
        .addr_mb   (mem_addr[ADDR_W-1:MB_SHIFT]),
        .in_window (in_window)
    );

    tseg_access_gate u_gate (
        .ctrl_q     (ctrl_q),
        .ext_q      (ext_q),
        .in_window  (in_window),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_smm    (mem_smm),
        .dram_rdata (dram_rdata),
        .mem_rdata  (mem_rdata),
        .dram_we    (dram_we),
        .blocked    (mem_blocked)
    );

    assign dram_addr  = mem_addr;
    assign dram_wdata = mem_wdata;
endmodule

// File: rtl/tseg_guard_checker.sv
module tseg_guard_checker (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr,
    input logic       cfg_sel,
    input logic [7:0] cfg_wdata,
    input logic [3:0] ctrl_bits,
    input logic [2:0] ext_bits,
    input logic       mem_req,
    input logic       mem_we,
    input logic       mem_smm,
    input logic [7:0] mem_rdata,
    input logic       dram_we,
    input logic       blocked
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (ctrl_bits == 4'h0 && ext_bits == 3'h0)); // R1

    AST_OPEN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_sel && !ctrl_bits[2])
        |=> ctrl_bits[0] == $past(cfg_wdata[0] && !cfg_wdata[2])); // R2

    AST_LOCK_KILLS_OPEN: assert property (@(posedge clk) disable iff (rst)
        ctrl_bits[2] |-> !ctrl_bits[0]); // R3

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        ctrl_bits[2] |=> ctrl_bits[2]); // R4

    AST_REFUSED_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && blocked) |-> mem_rdata == 8'hFF); // R7

    AST_REFUSED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        blocked |-> !dram_we); // R8

    AST_SMM_PASSES: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_smm) |-> !blocked); // R10

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ctrl_bits[2] |=> ($stable(ctrl_bits) && $stable(ext_bits))); // R12
endmodule

bind tseg_guard_top tseg_guard_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .ctrl_bits (ctrl_q),
    .ext_bits  (ext_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_smm   (mem_smm),
    .mem_rdata (mem_rdata),
    .dram_we   (dram_we),
    .blocked   (mem_blocked)
);

// File: tb/tseg_guard_top_test.sv
`timescale 1ns/1ps
module tseg_guard_top_test;
    localparam int RAM_MB = 128;
    localparam int EXT_MB = 16;
    localparam int AW     = $clog2(RAM_MB) + 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [7:0]    cfg_wdata = 8'h00;
    logic [7:0]    cfg_rdata;
    logic          mem_req = 1'b0;
    logic          mem_we = 1'b0;
    logic          mem_smm = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [7:0]    mem_wdata = 8'h00;
    logic [7:0]    mem_rdata;
    logic          mem_blocked;
    logic [AW-1:0] dram_addr;
    logic          dram_we;
    logic [7:0]    dram_wdata;
    logic [7:0]    dram_rdata;

    logic [7:0] dmem [0:1023];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    initial for (int i = 0; i < 1024; i++) dmem[i] = 8'h00;
    always @(posedge clk) if (dram_we) dmem[dram_addr[9:0]] <= dram_wdata;
    always_comb dram_rdata = dmem[dram_addr[9:0]];

    tseg_guard_top #(.RAM_MB(RAM_MB), .EXT_TSEG_MB(EXT_MB)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_smm(mem_smm), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_blocked(mem_blocked),
        .dram_addr(dram_addr), .dram_we(dram_we), .dram_wdata(dram_wdata),
        .dram_rdata(dram_rdata)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic cfg_write(input logic sel, input logic [7:0] d);
        @(negedge clk); cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic sel, output logic [7:0] d);
        @(negedge clk); cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic mem_read(input logic [AW-1:0] a, input logic smm, output logic [7:0] d);
        @(negedge clk); mem_addr = a; mem_smm = smm; mem_we = 1'b0; mem_req = 1'b1;
        #1 d = mem_rdata;
        mem_req = 1'b0;
    endtask

    task automatic mem_write(input logic [AW-1:0] a, input logic smm, input logic [7:0] d);
        @(negedge clk); mem_addr = a; mem_smm = smm; mem_we = 1'b1; mem_wdata = d; mem_req = 1'b1;
        @(negedge clk); mem_req = 1'b0; mem_we = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        do_reset();
        cfg_read(1'b0, v); check("R1 ctrl reset", v, 8'h00);
        cfg_read(1'b1, v); check("R1 ext reset", v, 8'h00);
        mem_write(AW'((RAM_MB << 20) - 1), 1'b0, 8'hA5);
        mem_read(AW'((RAM_MB << 20) - 1), 1'b0, v); check("R1 top byte open", v, 8'hA5);
    endtask

    task automatic t_open_unlocked();
        logic [7:0] v;
        do_reset();
        cfg_write(1'b0, 8'h01); cfg_read(1'b0, v); check("R2 open set", v, 8'h01);
        cfg_write(1'b0, 8'h00); cfg_read(1'b0, v); check("R2 open clear", v, 8'h00);
        cfg_write(1'b0, 8'hFB); cfg_read(1'b0, v); check("R2 bits open close gen", v, 8'h0B);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        do_reset();
        cfg_write(1'b0, 8'h01);
        cfg_write(1'b0, 8'h05); cfg_read(1'b0, v); check("R3 lock clears open", v, 8'h04);
        cfg_write(1'b0, 8'h01); cfg_read(1'b0, v); check("R3 open stays 0", v, 8'h04);
        cfg_write(1'b0, 8'h00); cfg_read(1'b0, v); check("R4 lock sticky", v, 8'h04);
        do_reset();
        cfg_read(1'b0, v); check("R4 reset clears lock", v, 8'h00);
        cfg_write(1'b0, 8'h01); cfg_read(1'b0, v); check("R4 open writable again", v, 8'h01);
    endtask

    task automatic t_size(input logic [1:0] code, input int mb, input string tag);
        logic [7:0] v;
        logic [AW-1:0] base;
        base = AW'((RAM_MB - mb) << 20);
        do_reset();
        mem_write(base, 1'b0, 8'h33);
        cfg_write(1'b1, {5'b0, code, 1'b1});
        cfg_read(1'b1, v); check({tag, " ext readback"}, v, {5'b0, code, 1'b1});
        cfg_write(1'b0, 8'h0A);
        cfg_write(1'b0, 8'h0E);
        mem_write(base - 1, 1'b0, 8'h5A);
        mem_read(base - 1, 1'b0, v); check({"R9 ", tag, " below base"}, v, 8'h5A);
        mem_read(base, 1'b0, v); check({"R7 ", tag, " base reads FF"}, v, 8'hFF);
        mem_write(base, 1'b0, 8'h77);
        mem_read(base, 1'b0, v); check({"R8 ", tag, " write dropped"}, v, 8'hFF);
        mem_read(base, 1'b1, v); check({"R10 ", tag, " smm sees old"}, v, 8'h33);
        mem_write(base, 1'b1, 8'h44);
        mem_read(base, 1'b1, v); check({"R10 ", tag, " smm write"}, v, 8'h44);
    endtask

    task automatic t_open_pass();
        logic [7:0] v;
        logic [AW-1:0] base;
        base = AW'((RAM_MB - 1) << 20);
        do_reset();
        mem_write(base, 1'b1, 8'h21);
        cfg_write(1'b1, 8'h01);
        cfg_write(1'b0, 8'h09);
        mem_read(base, 1'b0, v); check("R11 open passes", v, 8'h21);
        cfg_write(1'b0, 8'h0B);
        mem_read(base, 1'b0, v); check("R11 open+close blocks", v, 8'hFF);
        @(negedge clk); mem_addr = base; mem_smm = 1'b0; mem_we = 1'b0; mem_req = 1'b1;
        #1 check("R8 blocked flag", mem_blocked, 1);
        mem_req = 1'b0;
    endtask

    task automatic t_freeze();
        logic [7:0] v;
        do_reset();
        cfg_write(1'b1, 8'h01);
        cfg_write(1'b0, 8'h0E);
        cfg_write(1'b1, 8'h04);
        cfg_read(1'b1, v); check("R12 ext frozen", v, 8'h01);
        cfg_write(1'b0, 8'h00);
        cfg_read(1'b0, v); check("R12 ctrl frozen", v, 8'h0E);
        mem_write(AW'((RAM_MB - 2) << 20), 1'b0, 8'h66);
        mem_read(AW'((RAM_MB - 2) << 20), 1'b0, v); check("R12 window not moved", v, 8'h66);
        mem_read(AW'((RAM_MB - 1) << 20), 1'b0, v); check("R12 window still on", v, 8'hFF);
    endtask

    task automatic t_timing();
        logic [7:0] v;
        logic [AW-1:0] base;
        base = AW'((RAM_MB - 1) << 20);
        do_reset();
        mem_write(base, 1'b1, 8'h19);
        cfg_write(1'b1, 8'h01);
        @(negedge clk);
        mem_addr = base; mem_smm = 1'b0; mem_we = 1'b0; mem_req = 1'b1;
        cfg_sel = 1'b0; cfg_wdata = 8'h0A; cfg_wr = 1'b1;
        #1 check("R13 before edge old config", mem_rdata, 8'h19);
        @(negedge clk); cfg_wr = 1'b0;
        #1 check("R13 after edge new config", mem_rdata, 8'hFF);
        mem_req = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_open_unlocked();
        t_lock();
        t_size(2'd0, 1, "R5 1MB");
        t_size(2'd1, 2, "R5 2MB");
        t_size(2'd2, 8, "R5 8MB");
        t_size(2'd3, EXT_MB, "R6 ext");
        t_open_pass();
        t_freeze();
        t_timing();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule